// File: doc/BRIEF.md
# Four-Entry Register Exchange Sorter

This block holds four unsigned words in a small register file and puts them in ascending order in place. While the mode input is low, software-style strobes fill the registers by address. When mode goes high, a control machine walks a nested exchange loop over the registers. An outer index selects a base slot and an inner index scans every later slot. One less-than comparator decides whether the two words trade places. Each exchange goes through two operand registers and takes several cycles. No sorting network is built.

When the loop has finished, a done flag rises. The sorted words can then be read by address. The read port drives its word only while the read enable is high. The interface uses plain strobes with no back-pressure. A write is taken in the cycle its strobe is sampled. A read is combinational from the addressed register.

Top module: `exch_sorter`

## Requirements
- R1: After reset, every register reads as zero and done is 0.
- R2: While mode is 0, a cycle with wr_en high stores wr_data into the register selected by addr (0 to 3). A read of that address then returns the stored word.
- R3: While rd_en is 0, rd_data is all zeros. While rd_en is 1, rd_data is the register selected by addr.
- R4: While mode is 1, wr_en and wr_data leave the register contents unchanged.
- R5: When done is 1, register 0 ≤ register 1 ≤ register 2 ≤ register 3 as unsigned numbers, and the four words are the ones that were loaded.
- R6: Equal words are never exchanged, so duplicate values add no exchange cycles.
- R7: After mode is first sampled high with done low, done rises on the (16 + 2·S)th rising edge, counting that edge as the first. S is the number of exchanges the base-versus-later-slot loop performs.
- R8: done stays 1 while mode stays 1. It falls at the first rising edge that samples mode at 0.
- R9: Comparisons are unsigned, so 8'h80 sorts after 8'h7F.
- R10: Dropping mode to 0 before the loop finishes abandons the sort. done stays 0, and the next write with mode 0 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = load registers, 1 = sort |
| wr_en | input | 1 | Write strobe, used while mode is 0 |
| addr | input | IDX_W (2) | Register address, shared by writes and reads |
| wr_data | input | WIDTH (8) | Word to store |
| rd_en | input | 1 | Read enable; rd_data is zero while it is low |
| rd_data | output | WIDTH (8) | Addressed register while rd_en is high |
| done | output | 1 | Sort complete; held until mode returns to 0 |

## Verification
The hardest case to reach from the ports is a chain of exchanges on a single base slot. In that case the operand register must be reloaded from the slot that was just rewritten before the next compare. Only fully reversed or partly reversed loads exercise it several times in a row. The bench therefore loads descending, mixed, duplicate and sign-boundary patterns. It counts the edges until done and compares that count with an exchange count taken from its own model of the loop. A reload from the wrong slot therefore shows up as a wrong order, a wrong latency, or both.

// File: rtl/xsort_pkg.sv
package xsort_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LDA,
    ST_LDB,
    ST_CMP,
    ST_SWJ,
    ST_RELA,
    ST_DONE
  } xs_state_t;
endpackage

// File: rtl/xsort_regs.sv
module xsort_regs #(
  parameter int WIDTH = 8,
  parameter int NUM   = 4,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       waddr,
  input  logic [WIDTH-1:0]       wdata,
  output logic [NUM*WIDTH-1:0]   regs_flat
);
  logic [WIDTH-1:0] r [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r[g] <= '0;
      else if (we && waddr == IDX_W'(g))
        r[g] <= wdata;
    end
    assign regs_flat[g*WIDTH +: WIDTH] = r[g];
  end

  // R4: with no write strobe the contents must not move
  a_r4_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_flat));
endmodule

// File: rtl/xsort_idx.sv
module xsort_idx #(
  parameter int NUM   = 4,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_clr,
  input  logic             i_inc,
  input  logic             j_load,
  input  logic             j_inc,
  output logic [IDX_W-1:0] i_q,
  output logic [IDX_W-1:0] j_q,
  output logic             i_last,
  output logic             j_last
);
  localparam logic [IDX_W-1:0] I_END = IDX_W'(NUM - 2);
  localparam logic [IDX_W-1:0] J_END = IDX_W'(NUM - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      i_q <= '0;
    else if (i_clr)  i_q <= '0;
    else if (i_inc)  i_q <= i_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       j_q <= '0;
    else if (j_load)  j_q <= i_q + 1'b1;
    else if (j_inc)   j_q <= j_q + 1'b1;
  end

  assign i_last = (i_q == I_END);
  assign j_last = (j_q == J_END);

  // R7: the outer index never passes its last base slot
  a_r7_outer_range: assert property (@(posedge clk) disable iff (!rst_n)
    i_q <= I_END);
endmodule

// File: rtl/xsort_fsm.sv
module xsort_fsm
  import xsort_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode,
  input  logic      lt,
  input  logic      i_last,
  input  logic      j_last,
  output xs_state_t st,
  output logic      i_clr,
  output logic      i_inc,
  output logic      j_load,
  output logic      j_inc,
  output logic      a_ld,
  output logic      b_ld,
  output logic      fsm_we,
  output logic      wsel_j,
  output logic      done
);
  xs_state_t nx;
  logic      adv;

  always_comb begin
    nx     = st;
    i_clr  = 1'b0;
    i_inc  = 1'b0;
    j_load = 1'b0;
    j_inc  = 1'b0;
    a_ld   = 1'b0;
    b_ld   = 1'b0;
    fsm_we = 1'b0;
    wsel_j = 1'b0;
    adv    = 1'b0;
    case (st)
      ST_IDLE: if (mode) begin i_clr = 1'b1; nx = ST_LDA; end
      ST_LDA:  begin a_ld = 1'b1; j_load = 1'b1; nx = ST_LDB; end
      ST_LDB:  begin b_ld = 1'b1; nx = ST_CMP; end
      ST_CMP:  if (lt) begin fsm_we = 1'b1; nx = ST_SWJ; end
               else adv = 1'b1;
      ST_SWJ:  begin fsm_we = 1'b1; wsel_j = 1'b1; nx = ST_RELA; end
      ST_RELA: begin a_ld = 1'b1; adv = 1'b1; end
      ST_DONE: nx = ST_DONE;
      default: nx = ST_IDLE;
    endcase
    if (adv) begin
      if (!j_last) begin
        j_inc = 1'b1;
        nx    = ST_LDB;
      end else if (!i_last) begin
        i_inc = 1'b1;
        nx    = ST_LDA;
      end else begin
        nx = ST_DONE;
      end
    end
    if (!mode) nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nx;
  end

  assign done = (st == ST_DONE);

  // R8: done holds while mode stays high
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode) |=> done);
  // R8 / R10: a low mode sample always leaves done low
  a_r10_mode_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> !done);
endmodule

// File: rtl/exch_sorter.sv
module exch_sorter
  import xsort_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NUM   = 4,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             done
);
  xs_state_t            st;
  logic                 i_clr, i_inc, j_load, j_inc;
  logic                 a_ld, b_ld, fsm_we, wsel_j;
  logic                 i_last, j_last, lt;
  logic [IDX_W-1:0]     i_q, j_q;
  logic [WIDTH-1:0]     a_q, b_q;
  logic [NUM*WIDTH-1:0] regs_flat;
  logic [WIDTH-1:0]     rv [NUM];
  logic [WIDTH-1:0]     ri_val, rj_val;
  logic                 rf_we;
  logic [IDX_W-1:0]     rf_addr;
  logic [WIDTH-1:0]     rf_data;
  logic                 ordered;

  for (genvar g = 0; g < NUM; g++) begin : g_unpack
    assign rv[g] = regs_flat[g*WIDTH +: WIDTH];
  end

  assign ri_val = rv[i_q];
  assign rj_val = rv[j_q];
  assign lt     = (b_q < a_q);   // unsigned compare

  // write port: external strobes in load mode, exchange writes in sort mode
  always_comb begin
    if (mode) begin
      rf_we   = fsm_we;
      rf_addr = wsel_j ? j_q : i_q;
      rf_data = wsel_j ? a_q : b_q;
    end else begin
      rf_we   = wr_en;
      rf_addr = addr;
      rf_data = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_ld) a_q <= ri_val;
      if (b_ld) b_q <= rj_val;
    end
  end

  assign rd_data = rd_en ? rv[addr] : '0;

  xsort_regs #(.WIDTH(WIDTH), .NUM(NUM), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_addr),
    .wdata(rf_data), .regs_flat(regs_flat)
  );

  xsort_idx #(.NUM(NUM), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .i_clr(i_clr), .i_inc(i_inc),
    .j_load(j_load), .j_inc(j_inc), .i_q(i_q), .j_q(j_q),
    .i_last(i_last), .j_last(j_last)
  );

  xsort_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode(mode), .lt(lt),
    .i_last(i_last), .j_last(j_last), .st(st),
    .i_clr(i_clr), .i_inc(i_inc), .j_load(j_load), .j_inc(j_inc),
    .a_ld(a_ld), .b_ld(b_ld), .fsm_we(fsm_we), .wsel_j(wsel_j),
    .done(done)
  );

  always_comb begin
    ordered = 1'b1;
    for (int k = 1; k < NUM; k++)
      if (rv[k] < rv[k-1]) ordered = 1'b0;
  end

  // R5: finished contents are ascending
  a_r5_sorted_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ordered);
  // R5: after the first exchange write the base slot holds the smaller word
  a_r5_swap_orders: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SWJ) |-> (ri_val < a_q));
  // R7: the inner index is always beyond the outer one while scanning
  a_r7_inner_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LDB || st == ST_CMP || st == ST_SWJ || st == ST_RELA) |-> (j_q > i_q));
endmodule

// File: tb/sim_exch_sorter.sv
module sim_exch_sorter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  exch_sorter u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    @(negedge clk);
    addr = 2'(a); wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = 2'(a); rd_en = 1'b1;
    #1 v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      chk(v == 8'h00, "R1 register clear", v, 0);
    end
  endtask

  task automatic t_write_read();
    logic [7:0] v;
    logic [7:0] pat [4] = '{8'h11, 8'hA5, 8'h3C, 8'hF0};
    for (int a = 0; a < 4; a++) wr(a, pat[a]);
    for (int a = 3; a >= 0; a--) begin
      rd(a, v);
      chk(v == pat[a], "R2 write then read", v, pat[a]);
    end
  endtask

  task automatic t_rd_disabled();
    @(negedge clk);
    addr = 2'd1; rd_en = 1'b0;
    #1 chk(rd_data == 8'h00, "R3 bus idle with rd_en low", rd_data, 0);
    rd_en = 1'b1;
    #1 chk(rd_data == 8'hA5, "R3 bus drives when enabled", rd_data, 8'hA5);
    rd_en = 1'b0;
  endtask

  // loads, sorts, checks order, latency and done behaviour; leaves mode low
  task automatic run_sort(input logic [7:0] a0, a1, a2, a3, input string nm,
                          input bit try_write);
    logic [7:0] m [4];
    logic [7:0] t, v;
    int sw = 0;
    int n = 0;
    m = '{a0, a1, a2, a3};
    for (int a = 0; a < 4; a++) wr(a, m[a]);
    for (int i = 0; i < 3; i++)
      for (int j = i + 1; j < 4; j++)
        if (m[j] < m[i]) begin t = m[i]; m[i] = m[j]; m[j] = t; sw++; end
    @(negedge clk);
    mode = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 200);
    chk(n == 16 + 2 * sw, {"R7 latency ", nm}, n, 16 + 2 * sw);
    if (try_write) begin
      wr(0, 8'hEE);   // R4: must be ignored while mode is 1
    end
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      chk(v == m[a], {"R5 sorted word ", nm}, v, m[a]);
    end
    if (try_write) begin
      rd(0, v);
      chk(v == m[0], "R4 write ignored in sort mode", v, m[0]);
    end
    @(negedge clk);
    chk(done == 1'b1, {"R8 done held ", nm}, int'(done), 1);
    mode = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, {"R8 done cleared ", nm}, int'(done), 0);
  endtask

  task automatic t_sorts();
    run_sort(8'h01, 8'h02, 8'h03, 8'h04, "ascending", 1'b0);
    run_sort(8'h04, 8'h03, 8'h02, 8'h01, "descending", 1'b1);
    run_sort(8'h5A, 8'h07, 8'hC3, 8'h21, "mixed", 1'b0);
    run_sort(8'h33, 8'h33, 8'h33, 8'h33, "R6 all equal", 1'b0);
    run_sort(8'h40, 8'h10, 8'h40, 8'h10, "R6 duplicates", 1'b0);
    run_sort(8'h80, 8'h7F, 8'hFF, 8'h00, "R9 unsigned", 1'b0);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) wr(a, 8'(40 - 10 * a));
    @(negedge clk);
    mode = 1'b1;
    repeat (5) @(negedge clk);
    mode = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10 done low after abort", int'(done), 0);
    repeat (30) @(negedge clk);
    chk(done == 1'b0, "R10 done stays low", int'(done), 0);
    wr(2, 8'h55);
    rd(2, v);
    chk(v == 8'h55, "R10 write accepted after abort", v, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_rd_disabled();
    t_sorts();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule